// File: doc/BRIEF.md
# Monitor Setup Serial Loader

This block takes in the byte-serial configuration stream of a window-comparator channel monitor and loads the monitor's settings from it. The first byte of a frame carries one alarm-clear request per channel, a three-bit conversion-delay code and an interrupt enable. Each channel in the active scan set then receives three bytes that hold its 12-bit lower and upper trip thresholds. Which channels are in the active scan set depends on two live inputs. The differential flag drops the odd channels. The two-bit scan limit drops every channel above it. A skipped channel costs no bytes in the stream.

The same register set can be streamed back out on a byte-wide readback port. The readback uses the layout of a write frame, except that the four alarm-clear positions of the first byte always read as ones. The readback bytes are taken directly from the live registers. A byte written in the same cycle therefore becomes visible only in the following cycle. Bus framing and acknowledge generation are handled outside this block. The mode inputs are expected to stay steady while a frame or a readback is in progress.

Top module: `setup_loader`

## Requirements
- R1: When a byte is accepted with `inFirst` high, the next clock edge loads `delayCode` from byte bits 3..1 and `intEn` from bit 0. No other byte changes these two outputs.
- R2: In the cycle after a first byte is accepted, `alarmClr[c]` equals bit (7-c) of that byte, so bit 7 belongs to channel 0. In all other cycles `alarmClr` is zero.
- R3: Each active channel takes three body bytes. Byte 1 sets lower bits 11..4. Byte 2 sets lower bits 3..0 from its bits 7..4 and upper bits 11..8 from its bits 3..0. Byte 3 sets upper bits 7..0. Each channel's thresholds appear on `lowerTh`/`upperTh` at bits [12c+11:12c].
- R4: Channels are visited in ascending order, starting at channel 0. Odd channels are skipped while `diffMode` is 1, and channels above `scanLimit` are always skipped. Skipped channels keep their values and consume no bytes.
- R5: A first byte arriving before a frame is complete starts a new frame at channel 0. Threshold fields that the cut-off frame did not reach keep their previous values.
- R6: Body bytes after the last expected byte of a frame are ignored. So are body bytes received after reset before any first byte. Thresholds change only on the edge that accepts a byte.
- R7: After reset every lower threshold is 0x000, every upper threshold is 0xFFF, `delayCode` is 0, `intEn` is 0, `alarmClr` is 0 and `rdValid` is 0.
- R8: A `rdStart` pulse makes `rdValid` high from the next cycle. `rdByte` then shows the first byte as {4'b1111, delayCode, intEn}, followed by three bytes per active channel in the R3 layout and the R4 order. Each `rdNext` while `rdValid` is high advances to the next byte.
- R9: `rdLast` is high exactly while the final readback byte is shown. `rdNext` on that byte drops `rdValid` in the next cycle. A `rdStart` at any time restarts the readback at the first byte, and it wins over a `rdNext` in the same cycle.
- R10: When a byte write and a readback of the same field fall in the same cycle, `rdByte` shows the value from before the write. The written value is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| diffMode | input | 1 | 1 = differential pairing, odd channels skipped |
| scanLimit | input | 2 | Highest channel index in the scan set |
| inByte | input | 8 | Write stream data byte |
| inValid | input | 1 | `inByte` is offered this cycle |
| inFirst | input | 1 | The offered byte is the first byte of a frame |
| inReady | output | 1 | Block accepts a byte every cycle (always high) |
| rdStart | input | 1 | Begin readback at the first byte |
| rdNext | input | 1 | Consumer takes the shown readback byte |
| rdByte | output | 8 | Readback byte |
| rdValid | output | 1 | `rdByte` is valid |
| rdLast | output | 1 | `rdByte` is the final byte of the readback |
| delayCode | output | 3 | Conversion delay code to the monitor |
| intEn | output | 1 | Interrupt enable to the monitor |
| alarmClr | output | 4 | One-cycle per-channel alarm clear pulses |
| lowerTh | output | 48 | Lower thresholds, 12 bits per channel |
| upperTh | output | 48 | Upper thresholds, 12 bits per channel |

## Verification
A write and a readback can fall in the same cycle. The case that matters is a write that lands on the very field the readback is showing. The bench provokes this by starting a readback and then streaming a new frame in lockstep with `rdNext`, so that every write hits the field currently on `rdByte`. Each readback byte is judged against a model state taken before that cycle's write, and the new value must appear in the following cycle. A first byte that arrives together with a readback header is covered too: the header must still show the old delay code and enable.

// File: rtl/msl_pkg.sv
package msl_pkg;
  localparam int NUM_CH = 4;
  localparam int TH_W   = 12;
  localparam int DLY_W  = 3;
  localparam int BYTE_W = 8;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int MID_LO = TH_W - BYTE_W;   // lower-threshold bits carried in byte 2
  localparam int MID_UP = BYTE_W - MID_LO; // upper-threshold bits carried in byte 2

  typedef struct packed {
    logic            hdrWe;
    logic            loHiWe;
    logic            midWe;
    logic            upLoWe;
    logic [CH_W-1:0] wrCh;
    logic            rdOn;
    logic            rdHdr;
    logic [CH_W-1:0] rdCh;
    logic [1:0]      rdPh;
  } strobe_t;

  function automatic logic [CH_W:0] nextCh(input logic [CH_W-1:0] cur, input logic diff);
    return {1'b0, cur} + (diff ? (CH_W+1)'(2) : (CH_W+1)'(1));
  endfunction
endpackage

// File: rtl/msl_ctrl.sv
module msl_ctrl
  import msl_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            diffMode,
  input  logic [CH_W-1:0] scanLimit,
  input  logic            inValid,
  input  logic            inFirst,
  input  logic            rdStart,
  input  logic            rdNext,
  output strobe_t         stb,
  output logic            rdValid,
  output logic            rdLast
);
  logic            wrOpen;
  logic [CH_W-1:0] wrCh;
  logic [1:0]      wrPh;
  logic            rdOn;
  logic            rdHdr;
  logic [CH_W-1:0] rdCh;
  logic [1:0]      rdPh;

  logic            takeHdr;
  logic            takeBody;
  logic [CH_W:0]   wrNext;
  logic            wrMore;
  logic [CH_W:0]   rdNextCh;
  logic            rdMore;

  always_comb begin
    takeHdr  = inValid && inFirst;
    takeBody = inValid && !inFirst && wrOpen;
    wrNext   = nextCh(wrCh, diffMode);
    wrMore   = wrNext <= {1'b0, scanLimit};
    rdNextCh = nextCh(rdCh, diffMode);
    rdMore   = rdNextCh <= {1'b0, scanLimit};

    stb.hdrWe  = takeHdr;
    stb.loHiWe = takeBody && (wrPh == 2'd0);
    stb.midWe  = takeBody && (wrPh == 2'd1);
    stb.upLoWe = takeBody && (wrPh == 2'd2);
    stb.wrCh   = wrCh;
    stb.rdOn   = rdOn;
    stb.rdHdr  = rdHdr;
    stb.rdCh   = rdCh;
    stb.rdPh   = rdPh;

    rdValid = rdOn;
    rdLast  = rdOn && !rdHdr && (rdPh == 2'd2) && !rdMore;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrOpen <= 1'b0;
      wrCh   <= '0;
      wrPh   <= '0;
    end else if (takeHdr) begin
      wrOpen <= 1'b1;
      wrCh   <= '0;
      wrPh   <= '0;
    end else if (takeBody) begin
      if (wrPh == 2'd2) begin
        wrPh <= '0;
        if (wrMore) wrCh <= wrNext[CH_W-1:0];
        else        wrOpen <= 1'b0;
      end else begin
        wrPh <= wrPh + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOn  <= 1'b0;
      rdHdr <= 1'b0;
      rdCh  <= '0;
      rdPh  <= '0;
    end else if (rdStart) begin
      rdOn  <= 1'b1;
      rdHdr <= 1'b1;
      rdCh  <= '0;
      rdPh  <= '0;
    end else if (rdNext && rdOn) begin
      if (rdHdr) begin
        rdHdr <= 1'b0;
      end else if (rdPh == 2'd2) begin
        rdPh <= '0;
        if (rdMore) rdCh <= rdNextCh[CH_W-1:0];
        else        rdOn <= 1'b0;
      end else begin
        rdPh <= rdPh + 2'd1;
      end
    end
  end
endmodule

// File: rtl/msl_datapath.sv
module msl_datapath
  import msl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [BYTE_W-1:0]      inByte,
  input  strobe_t                stb,
  output logic [DLY_W-1:0]       delayCode,
  output logic                   intEn,
  output logic [NUM_CH-1:0]      alarmClr,
  output logic [NUM_CH*TH_W-1:0] lowerTh,
  output logic [NUM_CH*TH_W-1:0] upperTh,
  output logic [BYTE_W-1:0]      rdByte
);
  logic [TH_W-1:0] loR [NUM_CH];
  logic [TH_W-1:0] upR [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCode <= '0;
      intEn     <= 1'b0;
    end else if (stb.hdrWe) begin
      delayCode <= inByte[DLY_W:1];
      intEn     <= inByte[0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic hit;
    assign hit = (stb.wrCh == CH_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) alarmClr[g] <= 1'b0;
      else       alarmClr[g] <= stb.hdrWe & inByte[BYTE_W-1-g];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loR[g] <= '0;
        upR[g] <= '1;
      end else if (hit) begin
        if (stb.loHiWe) loR[g][TH_W-1:MID_LO] <= inByte;
        if (stb.midWe) begin
          loR[g][MID_LO-1:0]         <= inByte[BYTE_W-1:MID_UP];
          upR[g][TH_W-1:BYTE_W]      <= inByte[MID_UP-1:0];
        end
        if (stb.upLoWe) upR[g][BYTE_W-1:0] <= inByte;
      end
    end

    assign lowerTh[g*TH_W +: TH_W] = loR[g];
    assign upperTh[g*TH_W +: TH_W] = upR[g];
  end

  always_comb begin
    rdByte = '0;
    if (stb.rdOn) begin
      if (stb.rdHdr) begin
        rdByte = {{NUM_CH{1'b1}}, delayCode, intEn};
      end else begin
        case (stb.rdPh)
          2'd0:    rdByte = loR[stb.rdCh][TH_W-1:MID_LO];
          2'd1:    rdByte = {loR[stb.rdCh][MID_LO-1:0], upR[stb.rdCh][TH_W-1:BYTE_W]};
          default: rdByte = upR[stb.rdCh][BYTE_W-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/setup_loader.sv
module setup_loader
  import msl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   diffMode,
  input  logic [CH_W-1:0]        scanLimit,
  input  logic [BYTE_W-1:0]      inByte,
  input  logic                   inValid,
  input  logic                   inFirst,
  output logic                   inReady,
  input  logic                   rdStart,
  input  logic                   rdNext,
  output logic [BYTE_W-1:0]      rdByte,
  output logic                   rdValid,
  output logic                   rdLast,
  output logic [DLY_W-1:0]       delayCode,
  output logic                   intEn,
  output logic [NUM_CH-1:0]      alarmClr,
  output logic [NUM_CH*TH_W-1:0] lowerTh,
  output logic [NUM_CH*TH_W-1:0] upperTh
);
  strobe_t stb;

  assign inReady = 1'b1;

  msl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .diffMode(diffMode), .scanLimit(scanLimit),
    .inValid(inValid), .inFirst(inFirst), .rdStart(rdStart), .rdNext(rdNext),
    .stb(stb), .rdValid(rdValid), .rdLast(rdLast)
  );

  msl_datapath uData (
    .clk(clk), .rstN(rstN), .inByte(inByte), .stb(stb),
    .delayCode(delayCode), .intEn(intEn), .alarmClr(alarmClr),
    .lowerTh(lowerTh), .upperTh(upperTh), .rdByte(rdByte)
  );
endmodule

// File: rtl/msl_checker.sv
module msl_checker
  import msl_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   inFirst,
  input logic                   rdStart,
  input logic                   rdNext,
  input logic                   rdValid,
  input logic                   rdLast,
  input logic [BYTE_W-1:0]      rdByte,
  input logic [NUM_CH-1:0]      alarmClr,
  input logic [DLY_W-1:0]       delayCode,
  input logic                   intEn,
  input logic [NUM_CH*TH_W-1:0] lowerTh,
  input logic [NUM_CH*TH_W-1:0] upperTh
);
  a_r1_cfg_only_on_hdr: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid && inFirst) |-> ($stable(delayCode) && $stable(intEn)));

  a_r2_clr_after_hdr: assert property (@(posedge clk) disable iff (!rstN)
    (alarmClr != '0) |-> $past(inValid && inFirst));

  a_r6_th_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> ($stable(lowerTh) && $stable(upperTh)));

  a_r8_start_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdStart |=> rdValid);

  a_r8_hdr_ones: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdStart)) |-> (rdByte[BYTE_W-1 -: NUM_CH] == {NUM_CH{1'b1}}));

  a_r9_last_in_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdValid);

  a_r9_end_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (rdLast && rdNext && !rdStart) |=> !rdValid);
endmodule

bind setup_loader msl_checker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
  .rdStart(rdStart), .rdNext(rdNext), .rdValid(rdValid), .rdLast(rdLast),
  .rdByte(rdByte), .alarmClr(alarmClr), .delayCode(delayCode), .intEn(intEn),
  .lowerTh(lowerTh), .upperTh(upperTh)
);

// File: tb/setup_loader_test.sv
module setup_loader_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        diffMode = 1'b0;
  logic [1:0]  scanLimit = 2'd3;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0;
  logic        inFirst = 1'b0;
  logic        inReady;
  logic        rdStart = 1'b0;
  logic        rdNext = 1'b0;
  logic [7:0]  rdByte;
  logic        rdValid;
  logic        rdLast;
  logic [2:0]  delayCode;
  logic        intEn;
  logic [3:0]  alarmClr;
  logic [47:0] lowerTh;
  logic [47:0] upperTh;

  always #10 clk = ~clk;

  setup_loader uut (
    .clk(clk), .rstN(rstN), .diffMode(diffMode), .scanLimit(scanLimit),
    .inByte(inByte), .inValid(inValid), .inFirst(inFirst), .inReady(inReady),
    .rdStart(rdStart), .rdNext(rdNext), .rdByte(rdByte), .rdValid(rdValid),
    .rdLast(rdLast), .delayCode(delayCode), .intEn(intEn), .alarmClr(alarmClr),
    .lowerTh(lowerTh), .upperTh(upperTh)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string rdTag = "R8";

  int mLo[4];
  int mUp[4];
  int mDly;
  int mIe;
  int mClr;
  int wq[$];
  int rq[$];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void buildList(ref int q[$], input bit withHdr);
    q.delete();
    if (withHdr) q.push_back(-1);
    for (int c = 0; c < 4; c++)
      if (c <= int'(scanLimit) && (!diffMode || (c % 2 == 0)))
        for (int p = 0; p < 3; p++) q.push_back(c * 3 + p);
  endfunction

  function automatic int expByte(input int e);
    int ch;
    int ph;
    if (e < 0) return (15 << 4) | (mDly << 1) | mIe;
    ch = e / 3;
    ph = e % 3;
    if (ph == 0) return mLo[ch] >> 4;
    if (ph == 1) return ((mLo[ch] & 15) << 4) | (mUp[ch] >> 8);
    return mUp[ch] & 255;
  endfunction

  task automatic compare();
    for (int c = 0; c < 4; c++) begin
      chk("R3 lower", lowerTh[c*12 +: 12], mLo[c]);
      chk("R3 upper", upperTh[c*12 +: 12], mUp[c]);
    end
    chk("R1 delay", delayCode, mDly);
    chk("R1 intEn", intEn, mIe);
    chk("R2 alarmClr", alarmClr, mClr);
    chk("R8 rdValid", rdValid, rq.size() > 0);
    if (rq.size() > 0) begin
      chk(rdTag, rdByte, expByte(rq[0]));
      chk("R9 rdLast", rdLast, rq.size() == 1);
    end
  endtask

  task automatic modelStep(input bit v, input bit f, input int b, input bit rs, input bit rn);
    int e;
    int ch;
    mClr = 0;
    if (v && f) begin
      mDly = (b >> 1) & 7;
      mIe  = b & 1;
      for (int c = 0; c < 4; c++) mClr |= ((b >> (7 - c)) & 1) << c;
      buildList(wq, 0);
    end else if (v && wq.size() > 0) begin
      e  = wq.pop_front();
      ch = e / 3;
      case (e % 3)
        0: mLo[ch] = (b << 4) | (mLo[ch] & 15);
        1: begin
             mLo[ch] = (mLo[ch] & 'hFF0) | (b >> 4);
             mUp[ch] = ((b & 15) << 8) | (mUp[ch] & 255);
           end
        default: mUp[ch] = (mUp[ch] & 'hF00) | b;
      endcase
    end
    if (rs) buildList(rq, 1);
    else if (rn && rq.size() > 0) void'(rq.pop_front());
  endtask

  task automatic cyc(input bit v, input bit f, input int b, input bit rs, input bit rn);
    compare();
    inValid = v;
    inFirst = f;
    inByte  = 8'(b);
    rdStart = rs;
    rdNext  = rn;
    modelStep(v, f, b, rs, rn);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic sendTh(input int lo, input int up);
    cyc(1, 0, lo >> 4, 0, 0);
    cyc(1, 0, ((lo & 15) << 4) | (up >> 8), 0, 0);
    cyc(1, 0, up & 255, 0, 0);
  endtask

  task automatic thIs(input int ch, input int lo, input int up, input string tag);
    chk(tag, lowerTh[ch*12 +: 12], lo);
    chk(tag, upperTh[ch*12 +: 12], up);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin mLo[c] = 0; mUp[c] = 'hFFF; end
    mDly = 0; mIe = 0; mClr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7 reset state
    for (int c = 0; c < 4; c++) thIs(c, 'h000, 'hFFF, "R7");
    chk("R7 intEn", intEn, 0);
    chk("R7 delay", delayCode, 0);
    chk("R7 rdValid", rdValid, 0);
    chk("R7 inReady", inReady, 1);

    // R6 body bytes before any frame start
    for (int i = 0; i < 3; i++) cyc(1, 0, 'h55, 0, 0);
    idle(1);
    thIs(0, 'h000, 'hFFF, "R6");

    // R1 R2 R3 full single-ended frame
    diffMode = 0; scanLimit = 3;
    cyc(1, 1, 'hA5, 0, 0);
    chk("R2 pulse", alarmClr, 4'b0101);
    for (int c = 0; c < 4; c++) sendTh('h123 + c * 'h111, 'hABC - c);
    idle(2);
    thIs(1, 'h234, 'hABB, "R3");
    chk("R1 delay", delayCode, 2);
    chk("R1 intEn", intEn, 1);

    // R4 differential mode skips odd channels
    diffMode = 1; scanLimit = 3;
    cyc(1, 1, 'h0E, 0, 0);
    sendTh('h010, 'hF01);
    sendTh('h020, 'hF02);
    idle(2);
    thIs(0, 'h010, 'hF01, "R4");
    thIs(2, 'h020, 'hF02, "R4");
    thIs(1, 'h234, 'hABB, "R4");
    thIs(3, 'h456, 'hAB9, "R4");

    // R6 bytes beyond scan limit ignored
    diffMode = 0; scanLimit = 1;
    cyc(1, 1, 'h00, 0, 0);
    sendTh('h111, 'h222);
    sendTh('h333, 'h444);
    for (int i = 0; i < 4; i++) cyc(1, 0, 'hFF, 0, 0);
    idle(1);
    thIs(2, 'h020, 'hF02, "R6");
    thIs(1, 'h333, 'h444, "R6");

    // R5 early end then restart
    scanLimit = 3;
    cyc(1, 1, 'h01, 0, 0);
    cyc(1, 0, 'h9A, 0, 0);
    cyc(1, 0, 'hBC, 0, 0);
    cyc(1, 1, 'h01, 0, 0);
    idle(1);
    thIs(0, 'h9AB, 'hC22, "R5");
    cyc(1, 0, 'h77, 0, 0);
    idle(1);
    thIs(0, 'h77B, 'hC22, "R5");

    // R8 full readback
    cyc(0, 0, 0, 1, 0);
    chk("R8 header", rdByte >> 4, 'hF);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 1);
    chk("R8 ended", rdValid, 0);

    // R10 write and readback of the same field in the same cycle
    rdTag = "R10";
    diffMode = 1; scanLimit = 2;
    cyc(0, 0, 0, 1, 0);
    cyc(1, 1, 'h55, 0, 1);
    cyc(1, 0, 'hDE, 0, 1);
    chk("R10 pre-write", rdByte, 'hBC);
    cyc(1, 0, 'hAD, 0, 1);
    cyc(1, 0, 'hBE, 0, 1);
    cyc(1, 0, 'h12, 0, 1);
    cyc(1, 0, 'h34, 0, 1);
    cyc(1, 0, 'h56, 0, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1);
    thIs(0, 'hDEA, 'hDBE, "R10");

    // R9 restart mid-stream, start wins over next
    rdTag = "R9";
    diffMode = 0; scanLimit = 3;
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 1);
    chk("R9 restart", rdByte >> 4, 'hF);
    chk("R9 valid", rdValid, 1);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1);
    chk("R9 drained", rdValid, 0);
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule